// File: doc/BRIEF.md
# Streaming Sink Freeze Bridge

This bridge sits on a valid/ready stream between a source in the static logic and a sink inside a region that is about to be reconfigured. While `freeze` is low it is transparent. Ready, valid and the payload (data, start/end of packet, channel) pass straight through in the same cycle. While `freeze` is high it shields the region. Nothing is forwarded to the region's sink. The ready signal it returns to the static source then depends on the configured mode.

In packet mode the bridge records, per channel, which packets are open. When freeze rises, ready is held high so that every open packet can drain. The drained beats are accepted and then discarded. Once the last open channel has had its end-of-packet beat accepted, ready drops and stays low until freeze falls. In stream mode ready stays low for the entire freeze period.

Traffic that the static logic offers into a frozen region raises a sticky `illegal_request` flag. In stream mode this is any valid beat. In packet mode it is a valid start-of-packet beat. The flag is cleared by reset or when freeze falls. Back-pressure follows a fixed ready latency L (parameter `READY_LATENCY`). A beat counts as transferred only when valid is high in cycle t and ready was high in cycle t−L. This rule applies to the beats the bridge accepts from the source and to the beats it forwards to the region.

Top module: `sfb_sink_bridge`

## Requirements
- R1: With freeze low, `src_ready` equals `snk_ready` in the same cycle, and `snk_data`, `snk_sop`, `snk_eop` and `snk_channel` equal the source payload in the same cycle.
- R2: While freeze is high, `snk_valid` is low.
- R3: In packet mode (`packet_mode`=1), while freeze is high and at least one channel has an open packet, `src_ready` is high.
- R4: Packet tracking is per channel. The drain ends only after every channel that was open has had an end-of-packet beat accepted. Closing one of two open channels leaves `src_ready` high.
- R5: In packet mode, once no packet is open during freeze, `src_ready` is low for the rest of the freeze. A start-of-packet beat seen during freeze opens no new packet.
- R6: In stream mode (`packet_mode`=0), `src_ready` is low in every cycle that freeze is high.
- R7: In stream mode, a cycle with freeze and `src_valid` both high sets `illegal_request` from the next cycle on.
- R8: In packet mode, a cycle with freeze, `src_valid` and `src_sop` high sets `illegal_request` from the next cycle on. Drain beats without start-of-packet do not set it.
- R9: `illegal_request` stays high while freeze stays high. It is low in the cycle after freeze falls.
- R10: A source beat is accepted only if `src_ready` was high L cycles earlier. Outside freeze, `snk_valid` is high only when the source beat is accepted and `snk_ready` was high L cycles earlier. With L=0 this is simply valid while not frozen.
- R11: After reset `illegal_request` is low and no packet is open, so `src_ready` is low when freeze is high in packet mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freeze | input | 1 | High while the region is frozen |
| packet_mode | input | 1 | 1 = packet mode (drain open packets), 0 = stream mode |
| src_valid | input | 1 | Beat valid from static source |
| src_ready | output | 1 | Ready to static source |
| src_data | input | DATA_W | Beat payload from source |
| src_sop | input | 1 | Start-of-packet from source |
| src_eop | input | 1 | End-of-packet from source |
| src_channel | input | CHAN_W | Channel of the source beat |
| snk_valid | output | 1 | Beat valid toward the region's sink |
| snk_ready | input | 1 | Ready from the region's sink |
| snk_data | output | DATA_W | Payload toward the region |
| snk_sop | output | 1 | Start-of-packet toward the region |
| snk_eop | output | 1 | End-of-packet toward the region |
| snk_channel | output | CHAN_W | Channel toward the region |
| illegal_request | output | 1 | Sticky flag: traffic offered into a frozen region |

## Verification
The embedded assertions check the error flag on every cycle: it is set after an offending beat, it holds through freeze, and it clears after freeze falls. They also check that ready, once low during a packet-mode freeze, stays low, and that no channel opens while frozen. The bench's scenarios cover the rest. These are the per-channel drain with two channels open, the refusal of an end-of-packet beat offered before its latency window, the same-cycle passthrough, and the gating of forwarded valid by the region's delayed ready. A bench model checks these against the random traffic, freeze and mode patterns.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  typedef enum logic {
    SFB_STREAM = 1'b0,
    SFB_PACKET = 1'b1
  } sfb_mode_e;
endpackage

// File: rtl/sfb_ready_delay.sv
module sfb_ready_delay #(
  parameter int LATENCY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_now,
  output logic rdy_late
);
  generate
    if (LATENCY == 0) begin : g_zero
      assign rdy_late = rdy_now;
    end else begin : g_line
      logic [LATENCY-1:0] line_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= {line_q[LATENCY-1:0], rdy_now} >> 0;
      end
      assign rdy_late = line_q[LATENCY-1];
    end
  endgenerate
endmodule

// File: rtl/sfb_open_tracker.sv
module sfb_open_tracker #(
  parameter int CHAN_W = 2,
  localparam int NCH = 1 << CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              beat_acc,
  input  logic              beat_sop,
  input  logic              beat_eop,
  input  logic [CHAN_W-1:0] beat_chan,
  output logic [NCH-1:0]    open_mask
);
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic hit;
      assign hit = beat_acc && (beat_chan == CHAN_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        open_mask[c] <= 1'b0;
        else if (hit && beat_eop)          open_mask[c] <= 1'b0;
        else if (hit && beat_sop && !freeze) open_mask[c] <= 1'b1;
      end
    end
  endgenerate

  // R5: no channel becomes open while frozen
  assert_no_open_in_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ((open_mask & ~$past(open_mask)) == '0));
endmodule

// File: rtl/sfb_error_flag.sv
module sfb_error_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  input  logic packet_mode,
  input  logic beat_valid,
  input  logic beat_sop,
  output logic flag
);
  import sfb_pkg::*;
  logic freeze_q, offend;
  sfb_mode_e mode;
  assign mode   = sfb_mode_e'(packet_mode);
  assign offend = freeze && beat_valid && ((mode == SFB_STREAM) || beat_sop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
      flag     <= 1'b0;
    end else begin
      freeze_q <= freeze;
      if (freeze_q && !freeze) flag <= 1'b0;
      else if (offend)         flag <= 1'b1;
    end
  end

  assert_stream_offence_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && beat_valid && !packet_mode |=> flag);
  assert_packet_offence_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && beat_valid && beat_sop && packet_mode |=> flag);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag && freeze |=> flag);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freeze) |=> !flag);
endmodule

// File: rtl/sfb_sink_bridge.sv
module sfb_sink_bridge #(
  parameter int DATA_W        = 32,
  parameter int CHAN_W        = 2,
  parameter int READY_LATENCY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              packet_mode,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_sop,
  input  logic              src_eop,
  input  logic [CHAN_W-1:0] src_channel,
  output logic              snk_valid,
  input  logic              snk_ready,
  output logic [DATA_W-1:0] snk_data,
  output logic              snk_sop,
  output logic              snk_eop,
  output logic [CHAN_W-1:0] snk_channel,
  output logic              illegal_request
);
  localparam int NCH = 1 << CHAN_W;

  logic [NCH-1:0] open_mask;
  logic draining, src_rdy_late, snk_rdy_late, beat_acc;

  assign draining  = |open_mask;
  assign src_ready = freeze ? (packet_mode && draining) : snk_ready;
  assign beat_acc  = src_valid && src_rdy_late;

  sfb_ready_delay #(.LATENCY(READY_LATENCY)) u_src_dly (
    .clk(clk), .rst_n(rst_n), .rdy_now(src_ready), .rdy_late(src_rdy_late));
  sfb_ready_delay #(.LATENCY(READY_LATENCY)) u_snk_dly (
    .clk(clk), .rst_n(rst_n), .rdy_now(snk_ready), .rdy_late(snk_rdy_late));

  sfb_open_tracker #(.CHAN_W(CHAN_W)) u_track (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .beat_acc(beat_acc),
    .beat_sop(src_sop), .beat_eop(src_eop), .beat_chan(src_channel),
    .open_mask(open_mask));

  sfb_error_flag u_flag (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .packet_mode(packet_mode),
    .beat_valid(src_valid), .beat_sop(src_sop), .flag(illegal_request));

  generate
    if (READY_LATENCY == 0) begin : g_valid_l0
      assign snk_valid = !freeze && src_valid;
    end else begin : g_valid_ln
      assign snk_valid = !freeze && beat_acc && snk_rdy_late;
    end
  endgenerate

  assign snk_data    = src_data;
  assign snk_sop     = src_sop;
  assign snk_eop     = src_eop;
  assign snk_channel = src_channel;

  // R5: once the drain is over, ready stays low until freeze falls
  assert_drain_done_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && packet_mode && !src_ready |=> !src_ready || !freeze || !packet_mode);
endmodule

// File: tb/sfb_sink_bridge_test.sv
module sfb_sink_bridge_test;
  localparam int DW = 32, CW = 2;
  logic clk = 0, rst_n = 0;
  logic freeze = 0, packet_mode = 0, src_valid = 0, src_sop = 0, src_eop = 0, snk_ready = 0;
  logic [DW-1:0] src_data = '0;
  logic [CW-1:0] src_channel = '0;
  logic src_ready, snk_valid, snk_sop, snk_eop, illegal_request;
  logic [DW-1:0] snk_data;
  logic [CW-1:0] snk_channel;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [3:0] m_open = '0;
  logic m_prev_rdy = 0, m_prev_snk = 0, m_ill = 0, m_prev_frz = 0;

  always #4 clk = ~clk;

  sfb_sink_bridge #(.DATA_W(DW), .CHAN_W(CW), .READY_LATENCY(1)) uut (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .packet_mode(packet_mode),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .src_sop(src_sop), .src_eop(src_eop), .src_channel(src_channel),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
    .snk_sop(snk_sop), .snk_eop(snk_eop), .snk_channel(snk_channel),
    .illegal_request(illegal_request));

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_ready();
    return freeze ? (packet_mode && (m_open != 0)) : snk_ready;
  endfunction

  function automatic logic exp_valid();
    return !freeze && src_valid && m_prev_rdy && m_prev_snk;
  endfunction

  task automatic cyc(input logic f, input logic md, input logic v, input logic s,
                     input logic e, input logic [CW-1:0] ch, input logic sr);
    logic er, acc;
    @(negedge clk);
    freeze = f; packet_mode = md; src_valid = v; src_sop = s; src_eop = e;
    src_channel = ch; snk_ready = sr; src_data = $urandom;
    #1;
    er = exp_ready();
    check(src_ready, er, !f ? "R1" : (!md ? "R6" : (er ? "R3" : "R5")));
    check(snk_valid, exp_valid(), f ? "R2" : ((m_prev_rdy && m_prev_snk) ? "R1" : "R10"));
    check(snk_data == src_data && snk_sop == s && snk_eop == e && snk_channel == ch, 1'b1, "R1");
    check(illegal_request, m_ill, m_ill ? (md ? "R8" : "R7") : "R9");
    @(posedge clk);
    acc = v && m_prev_rdy;
    if (acc && e) m_open[ch] = 1'b0;
    else if (acc && s && !f) m_open[ch] = 1'b1;
    if (m_prev_frz && !f) m_ill = 0;
    else if (f && v && (!md || s)) m_ill = 1;
    m_prev_frz = f; m_prev_rdy = er; m_prev_snk = sr;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5FB1));
    freeze = 1; packet_mode = 1;
    repeat (3) @(posedge clk);
    #1;
    check(illegal_request, 1'b0, "R11");
    check(src_ready, 1'b0, "R11");
    @(negedge clk); rst_n = 1;
    // R4: open ch0 and ch1, freeze, close ch0 only -> still ready
    cyc(0, 1, 0, 0, 0, 0, 1);
    cyc(0, 1, 1, 1, 0, 0, 1);
    cyc(0, 1, 1, 1, 0, 1, 1);
    cyc(1, 1, 1, 0, 1, 0, 1);
    #2; check(src_ready, 1'b1, "R4");
    cyc(1, 1, 1, 0, 1, 1, 0);
    #2; check(src_ready, 1'b0, "R5");
    cyc(1, 1, 1, 1, 0, 2, 1);
    #2; check(illegal_request, 1'b1, "R8");
    cyc(0, 1, 0, 0, 0, 0, 1);
    #2; check(illegal_request, 1'b0, "R9");
    // R10: eop offered while ready was low L cycles earlier is refused
    cyc(0, 1, 1, 1, 0, 3, 1);
    cyc(0, 1, 0, 0, 0, 3, 0);
    cyc(1, 1, 1, 0, 1, 3, 0);
    #2; check(src_ready, 1'b1, "R10");
    cyc(1, 1, 1, 0, 1, 3, 0);
    #2; check(src_ready, 1'b0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 1);
    // R6 / R7: stream mode freeze
    cyc(1, 0, 1, 0, 0, 0, 1);
    #2; check(illegal_request, 1'b1, "R7");
    cyc(1, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic f, md;
      f  = ($urandom % 16) < 5 ? !freeze : freeze;
      if (i % 40 == 0) f = ($urandom % 3) == 0;
      md = freeze || f ? packet_mode : logic'($urandom % 2);
      cyc(f, md, logic'(($urandom % 3) != 0), logic'(($urandom % 4) == 0),
          logic'(($urandom % 4) == 0), CW'($urandom), logic'(($urandom % 4) != 0));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule